// File: doc/BRIEF.md
# Rounding Saturating Fixed-Point Multiplier

This block multiplies two signed fixed-point operands that share one compile-time count of fractional bits and returns their product in that same format. A value is held as a two's complement integer equal to the real value times 2^Q. For example, with Q = 8 the real value 1.5 is held as 384. The product is formed at double width first. A rounding bias of half an output LSB is added, and the sum is shifted arithmetically right by Q places. If the result falls outside the signed output range it is clamped to the nearest end of that range, and a flag marks the clamp.

Operands enter through a valid/ready handshake. The result leaves two cycles later with a valid strobe and the clamp flag, in the same cycle as the data. The pipeline never stalls. Once the block is out of reset it accepts one operand pair every cycle.

Top module: `qmul_round_sat`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `in_ready` are both low after that edge.
- R2: A pair taken on an edge where `in_valid` and `in_ready` are both high gives `out_valid` high exactly two edges later. An edge with no pair taken gives `out_valid` low two edges later. Pairs taken on consecutive edges come out on consecutive edges, in the same order.
- R3: For results inside the signed DATA_W range, `out_data` equals floor((a*b + 2^(Q-1)) / 2^Q). Here a and b are the operands read as two's complement integers, and the product is formed without loss.
- R4: A result that lies exactly on a half-LSB midpoint rounds toward positive infinity. With Q = 8, 1*128 gives 1 and -1*128 gives 0. A result just below a midpoint rounds down: 1*127 gives 0 and -1*129 gives -1.
- R5: A rescaled value above 2^(DATA_W-1)-1 yields `out_data` = 0x7FFF (for DATA_W = 16) with `out_sat` high.
- R6: A rescaled value below -2^(DATA_W-1) yields `out_data` = 0x8000 (for DATA_W = 16) with `out_sat` high.
- R7: A rescaled value inside the range, including the exact extremes 0x7FFF and 0x8000, is returned with `out_sat` low.
- R8: `in_ready` goes high on the first edge with `rst_n` high and stays high. A pair offered while `in_ready` is low is dropped and produces no result.
- R9: Elaboration is rejected when FRAC_BITS lies outside 1 to DATA_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair |
| in_a | input | DATA_W | Multiplicand, signed fixed point |
| in_b | input | DATA_W | Multiplier, signed fixed point |
| out_valid | output | 1 | Result strobe |
| out_data | output | DATA_W | Rounded, clamped product |
| out_sat | output | 1 | Result was clamped |

## Verification
The arithmetic is tested with four kinds of operand pairs.
- Ordinary mixed-sign pairs such as 1.5 times 2.0 confirm the rescaling shift.
- Pairs that land exactly on, or one count either side of, a half-LSB midpoint separate round-half-up from truncation and from round-half-away-from-zero.
- Pairs whose results sit exactly at the range ends, or one step beyond them, separate a clamp that fires too early from one that fires too late or not at all.
- Back-to-back streams and pairs offered during the reset-to-ready change expose latency, ordering and handshake faults.

// File: rtl/qmul_pkg.sv
// Package qmul_pkg
// Shared types for the fixed-point multiplier pipeline.
// Assumes nothing beyond a standard two's complement datapath.
package qmul_pkg;

    // Which end of the range, if any, the result was clamped to.
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_HIGH = 2'd1,
        CLAMP_LOW  = 2'd2
    } clamp_kind_e;

endpackage

// File: rtl/qmul_prod_stage.sv
// Module qmul_prod_stage
// First pipeline stage. Forms the exact double-width signed product of
// two operands and adds the half-LSB rounding bias.
// Assumes FRAC_BITS >= 1, so the bias is a whole power of two. The top
// checks this at elaboration.
module qmul_prod_stage #(
    parameter int DATA_W    = 16,
    parameter int FRAC_BITS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take_i,
    input  logic signed [DATA_W-1:0]   a_i,
    input  logic signed [DATA_W-1:0]   b_i,
    output logic                       vld_o,
    output logic signed [2*DATA_W-1:0] sum_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam logic signed [PROD_W-1:0] ROUND_BIAS =
        {{(PROD_W-1){1'b0}}, 1'b1} << (FRAC_BITS - 1);

    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;
    logic signed [PROD_W-1:0] prod;

    // Sign-extend both operands and form the lossless product plus bias.
    always_comb begin
        a_ext = PROD_W'(a_i);
        b_ext = PROD_W'(b_i);
        prod  = a_ext * b_ext;
    end

    // Valid bit: cleared by reset, set on every accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= take_i;
    end

    // Data register: holds the biased product; it needs no reset.
    always_ff @(posedge clk) begin
        if (take_i) sum_o <= prod + ROUND_BIAS;
    end

endmodule

// File: rtl/qmul_scale_sat.sv
// Module qmul_scale_sat
// Second pipeline stage. Shifts the biased product arithmetically right
// by FRAC_BITS and clamps the result to the signed DATA_W range.
// Assumes the input already carries the rounding bias.
module qmul_scale_sat
    import qmul_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FRAC_BITS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vld_i,
    input  logic signed [2*DATA_W-1:0] sum_i,
    output logic                       vld_o,
    output logic        [DATA_W-1:0]   data_o,
    output logic                       sat_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam logic signed [PROD_W-1:0] HI_LIM =
        (PROD_W)'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [PROD_W-1:0] LO_LIM = -HI_LIM - 1;
    localparam logic [DATA_W-1:0] HI_WORD = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] LO_WORD = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [PROD_W-1:0] scaled;
    clamp_kind_e              kind;
    logic        [DATA_W-1:0] clamped;

    // Rescale, then classify the result against the output range.
    always_comb begin
        scaled = sum_i >>> FRAC_BITS;
        if (scaled > HI_LIM)      kind = CLAMP_HIGH;
        else if (scaled < LO_LIM) kind = CLAMP_LOW;
        else                      kind = CLAMP_NONE;
    end

    // Select the clamp value or the low bits of the rescaled result.
    always_comb begin
        case (kind)
            CLAMP_HIGH: clamped = HI_WORD;
            CLAMP_LOW:  clamped = LO_WORD;
            default:    clamped = scaled[DATA_W-1:0];
        endcase
    end

    // Valid bit: cleared by reset, follows stage one.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Result and clamp flag registers.
    always_ff @(posedge clk) begin
        if (vld_i) begin
            data_o <= clamped;
            sat_o  <= (kind != CLAMP_NONE);
        end
    end

    // A clamped result must be one of the two range ends.
    assert_sat_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && sat_o) |-> (data_o == HI_WORD || data_o == LO_WORD));

endmodule

// File: rtl/qmul_round_sat.sv
// Module qmul_round_sat
// Top level. Provides the input handshake and chains the product stage
// with the rescale-and-clamp stage. Latency is two cycles and the
// pipeline never stalls.
// Assumes 1 <= FRAC_BITS <= DATA_W-1.
module qmul_round_sat #(
    parameter int DATA_W    = 16,
    parameter int FRAC_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sat
);
    localparam int PROD_W = 2 * DATA_W;

    // R9: reject a fractional bit count outside the usable range.
    if (FRAC_BITS < 1 || FRAC_BITS > DATA_W - 1) begin : g_bad_frac
        $error("FRAC_BITS must lie in 1..DATA_W-1");
    end

    logic                     take;
    logic                     s1_vld;
    logic signed [PROD_W-1:0] s1_sum;

    // Ready goes high on the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    assign take = in_valid && in_ready;

    qmul_prod_stage #(.DATA_W(DATA_W), .FRAC_BITS(FRAC_BITS)) u_prod (
        .clk   (clk),
        .rst_n (rst_n),
        .take_i(take),
        .a_i   ($signed(in_a)),
        .b_i   ($signed(in_b)),
        .vld_o (s1_vld),
        .sum_o (s1_sum)
    );

    qmul_scale_sat #(.DATA_W(DATA_W), .FRAC_BITS(FRAC_BITS)) u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (s1_vld),
        .sum_i (s1_sum),
        .vld_o (out_valid),
        .data_o(out_data),
        .sat_o (out_sat)
    );

    // Each result traces back to a pair taken two edges earlier.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(take, 2));

    // A filled stage one always moves into stage two.
    assert_pipe_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> out_valid);

    // The result sign follows the sign of the biased product.
    assert_sign_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[DATA_W-1] == $past(s1_sum[PROD_W-1])));

    // Once raised, ready stays high until reset.
    assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);

endmodule

// File: tb/qmul_round_sat_tb.sv
`timescale 1ns/1ps
module qmul_round_sat_tb_top;
    localparam int DW = 16;
    localparam int QF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_a = '0;
    logic [DW-1:0] in_b = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_sat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] a_q [0:7];
    logic [DW-1:0] b_q [0:7];

    always #2.5 clk = ~clk;

    qmul_round_sat #(.DATA_W(DW), .FRAC_BITS(QF)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_data(out_data), .out_sat(out_sat)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model written from R3..R7.
    task automatic model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         output logic [DW-1:0] res, output bit sat);
        longint p;
        longint s;
        p = longint'($signed(a)) * longint'($signed(b)) + (longint'(1) <<< (QF - 1));
        s = p >>> QF;
        sat = 1'b1;
        if (s > 32767)       res = 16'h7FFF;
        else if (s < -32768) res = 16'h8000;
        else begin
            res = s[DW-1:0];
            sat = 1'b0;
        end
    endtask

    // Feed n queued pairs back to back; check each result two edges later.
    task automatic run_batch(input string req, input int n);
        logic [DW-1:0] er;
        bit es;
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                model(a_q[i-2], b_q[i-2], er, es);
                chk("R2", {req, " valid"}, longint'(out_valid), 1);
                chk(req, "data", longint'($signed(out_data)), longint'($signed(er)));
                chk(req, "sat", longint'(out_sat), longint'(es));
            end else begin
                chk("R2", "idle before result", longint'(out_valid), 0);
            end
            if (i < n) begin
                in_valid = 1'b1;
                in_a = a_q[i];
                in_b = b_q[i];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        in_valid = 1'b1;
        in_a = 16'sd256;
        in_b = 16'sd256;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid in reset", longint'(out_valid), 0);
        chk("R1", "in_ready in reset", longint'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "in_ready after release", longint'(in_ready), 1);
        @(negedge clk);
        chk("R8", "pair offered while not ready, +1", longint'(out_valid), 0);
        @(negedge clk);
        chk("R8", "pair offered while not ready, +2", longint'(out_valid), 0);
    endtask

    task automatic t_basic();
        a_q[0] = 16'd384;           b_q[0] = 16'd512;   // 1.5*2.0
        a_q[1] = -16'sd384;         b_q[1] = 16'd512;
        a_q[2] = -16'sd640;         b_q[2] = -16'sd200;
        a_q[3] = 16'd0;             b_q[3] = 16'h7FFF;
        run_batch("R3", 4);
    endtask

    task automatic t_midpoint();
        a_q[0] = 16'd1;   b_q[0] = 16'd128;      // +0.5 LSB -> 1
        a_q[1] = -16'sd1; b_q[1] = 16'd128;      // -0.5 LSB -> 0
        a_q[2] = 16'd1;   b_q[2] = 16'd127;      // below midpoint -> 0
        a_q[3] = -16'sd1; b_q[3] = 16'd129;      // -> -1
        a_q[4] = 16'd3;   b_q[4] = 16'd128;      // 1.5 LSB -> 2
        run_batch("R4", 5);
    endtask

    task automatic t_clamp_hi();
        a_q[0] = 16'h7FFF; b_q[0] = 16'h7FFF;
        a_q[1] = 16'h8000; b_q[1] = 16'h8000;
        a_q[2] = 16'h7FFF; b_q[2] = 16'd257;
        run_batch("R5", 3);
    endtask

    task automatic t_clamp_lo();
        a_q[0] = 16'h7FFF; b_q[0] = 16'h8000;
        a_q[1] = 16'h8000; b_q[1] = 16'd257;
        run_batch("R6", 2);
    endtask

    task automatic t_edges();
        a_q[0] = 16'h7FFF; b_q[0] = 16'd256;     // exactly 0x7FFF
        a_q[1] = 16'h8000; b_q[1] = 16'd256;     // exactly 0x8000
        a_q[2] = 16'h7FFF; b_q[2] = 16'd255;
        run_batch("R7", 3);
    endtask

    task automatic t_stream();
        for (int i = 0; i < 8; i++) begin
            a_q[i] = DW'(i * 1000 - 3500);
            b_q[i] = DW'(i * 37 + 90);
        end
        run_batch("R2", 8);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_midpoint();
        t_clamp_hi();
        t_clamp_lo();
        t_edges();
        t_stream();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule